// File: doc/BRIEF.md
# Glyph Pixel Streamer

The block turns one character code into the pixels of an 8-wide, 16-tall character cell for a 16-bit colour display. A request carries the character code, a foreground colour and a background colour, all as RGB565 words. The block looks up the glyph in a small internal ROM. It then emits the cell as 128 colour words over a valid/ready stream: rows from top to bottom, and columns from left to right within each row. A set glyph bit becomes the foreground colour and a clear bit becomes the background colour.

A flag on the request opens a frame update. When the flag is set, the block places the display memory-write command word ahead of the pixels and marks it as a command on a separate output bit. Codes outside the stored range are drawn as a filled box. The block takes a new request only when the whole cell has been sent. A one-cycle done pulse marks that point.

Top module: `glyph_stream`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` and `done` are 0 and `req_ready` is 1.
- R2: A cell is exactly 128 pixel words. The stream runs through rows 0 to 15 in order and through columns 0 to 7 within each row. Each row is a 16-bit word whose bit 15 is column 0 and whose bit 8 is column 7. Bits 7..0 are padding and are never drawn.
- R3: A pixel whose glyph bit is 1 carries the request's foreground colour, and a pixel whose bit is 0 carries the background colour.
- R4: Stored codes run from 0x20 to 0x7E. Code 0x20 is blank. For codes 0x21 to 0x7E, rows 0, 1, 14 and 15 are 0, and row r in 2..13 is {rotate-left(code, r mod 8), 8'h00}.
- R5: With `req_open_frame` set, one word 0x002C with `out_is_cmd` = 1 comes before the first pixel. With the flag clear, no command word is sent.
- R6: A code below 0x20 or above 0x7E uses the default glyph. Every row of the default glyph is 16'hFF00, so all 128 pixels carry the foreground colour.
- R7: While `out_valid` is 1 and `out_ready` is 0, the output word, its kind and the row/column position hold until the word is taken.
- R8: `req_ready` is 1 only when no cell is in progress, so a request presented during a cell is not taken. `done` is high for exactly one cycle, the cycle after the last pixel is transferred. In that same cycle `req_ready` returns to 1.
- R9: Pixel words are presented with `out_is_cmd` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Character request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_code | input | 8 | Character code |
| req_fg | input | 16 | Foreground colour, RGB565 |
| req_bg | input | 16 | Background colour, RGB565 |
| req_open_frame | input | 1 | Send the memory-write command word before the pixels |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 16 | Pixel colour or command word |
| out_is_cmd | output | 1 | Output word is a command |
| done | output | 1 | One-cycle pulse after the cell's last pixel |

## Verification
Two things can coincide at the end of a cell: the done pulse and the acceptance of the next request. To provoke this, the bench raises a second request partway through a cell and holds it. During the rest of the cell, `req_ready` must stay low and every pixel must still match the first character. In the cycle that `done` is high, `req_ready` must be 1, so the held request is taken at that edge. The stream that follows must then match the second character, including its command word.

// File: rtl/glyph_pkg.sv
package glyph_pkg;

    localparam int CODE_W   = 8;
    localparam int PIX_W    = 16;
    localparam int GLYPH_W  = 8;
    localparam int GLYPH_H  = 16;
    localparam int COL_W    = $clog2(GLYPH_W);
    localparam int ROWIX_W  = $clog2(GLYPH_H);

    localparam logic [PIX_W-1:0]   CMD_MEM_WRITE = 16'h002C;
    localparam logic [CODE_W-1:0]  FIRST_CODE    = 8'h20;
    localparam logic [CODE_W-1:0]  LAST_CODE     = 8'h7E;
    localparam logic [CODE_W-1:0]  BLANK_CODE    = 8'h20;
    localparam int                 EDGE_ROWS     = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_PIX  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [PIX_W-1:0]  fg;
        logic [PIX_W-1:0]  bg;
    } cell_req_t;

    // Rotate a glyph-wide bit vector left by a small amount.
    function automatic logic [GLYPH_W-1:0] rot_left(input logic [GLYPH_W-1:0] v,
                                                    input logic [COL_W-1:0]   s);
        logic [2*GLYPH_W-1:0] twice;
        twice = {v, v} << s;
        return twice[2*GLYPH_W-1 -: GLYPH_W];
    endfunction

endpackage

// File: rtl/glyph_rom.sv
module glyph_rom
    import glyph_pkg::*;
#(
    parameter logic [CODE_W-1:0] LO_CODE = FIRST_CODE,
    parameter logic [CODE_W-1:0] HI_CODE = LAST_CODE
) (
    input  logic [CODE_W-1:0]  code,
    input  logic [ROWIX_W-1:0] row,
    output logic [GLYPH_W-1:0] lit_bits   // left-aligned part of the row word
);

    logic in_range;
    logic edge_row;

    assign in_range = (code >= LO_CODE) && (code <= HI_CODE);
    assign edge_row = (row < ROWIX_W'(EDGE_ROWS)) ||
                      (row > ROWIX_W'(GLYPH_H - 1 - EDGE_ROWS));

    // Content is computed rather than stored: each stored row word is
    // {lit_bits, padding}, with the padding always zero.
    always_comb begin
        if (!in_range) begin
            lit_bits = '1;                       // default glyph: filled box
        end else if (code == BLANK_CODE || edge_row) begin
            lit_bits = '0;
        end else begin
            lit_bits = rot_left(code[GLYPH_W-1:0], row[COL_W-1:0]);
        end
    end

endmodule

// File: rtl/colour_expand.sv
module colour_expand
    import glyph_pkg::*;
(
    input  logic [GLYPH_W-1:0] lit_bits,
    input  logic [COL_W-1:0]   col,
    input  logic [PIX_W-1:0]   fg,
    input  logic [PIX_W-1:0]   bg,
    output logic [PIX_W-1:0]   pixel
);

    logic [PIX_W-1:0] lane [GLYPH_W];

    // Most significant bit is the leftmost column.
    for (genvar i = 0; i < GLYPH_W; i++) begin : g_lane
        assign lane[i] = lit_bits[GLYPH_W-1-i] ? fg : bg;
    end

    assign pixel = lane[col];

endmodule

// File: rtl/pixel_sequencer.sv
module pixel_sequencer
    import glyph_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  cell_req_t          req_in,
    input  logic               req_open_frame,
    output logic               out_valid,
    input  logic               out_ready,
    output logic               is_cmd,
    output logic [ROWIX_W-1:0] row,
    output logic [COL_W-1:0]   col,
    output cell_req_t          cur,
    output logic               done
);

    localparam logic [COL_W-1:0]   LAST_COL = COL_W'(GLYPH_W - 1);
    localparam logic [ROWIX_W-1:0] LAST_ROW = ROWIX_W'(GLYPH_H - 1);

    seq_state_t          state_q;
    logic [ROWIX_W-1:0]  row_q;
    logic [COL_W-1:0]    col_q;
    cell_req_t           req_q;
    logic                done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            row_q   <= '0;
            col_q   <= '0;
            req_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q   <= req_in;
                        row_q   <= '0;
                        col_q   <= '0;
                        state_q <= req_open_frame ? ST_CMD : ST_PIX;
                    end
                end
                ST_CMD: begin
                    if (out_ready) state_q <= ST_PIX;
                end
                ST_PIX: begin
                    if (out_ready) begin
                        if (col_q == LAST_COL) begin
                            col_q <= '0;
                            if (row_q == LAST_ROW) begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                            end else begin
                                row_q <= row_q + 1'b1;
                            end
                        end else begin
                            col_q <= col_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign out_valid = (state_q != ST_IDLE);
    assign is_cmd    = (state_q == ST_CMD);
    assign row       = row_q;
    assign col       = col_q;
    assign cur       = req_q;
    assign done      = done_q;

    AST_STALL_POSITION: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PIX && !out_ready) |=> ($stable(row_q) && $stable(col_q))); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R8

    AST_BUSY_KEEPS_REQ: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(req_q)); // R8

endmodule

// File: rtl/glyph_stream.sv
module glyph_stream
    import glyph_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CODE_W-1:0] req_code,
    input  logic [PIX_W-1:0]  req_fg,
    input  logic [PIX_W-1:0]  req_bg,
    input  logic              req_open_frame,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PIX_W-1:0]  out_data,
    output logic              out_is_cmd,
    output logic              done
);

    cell_req_t           req_in;
    cell_req_t           cur;
    logic [ROWIX_W-1:0]  row;
    logic [COL_W-1:0]    col;
    logic [GLYPH_W-1:0]  lit_bits;
    logic [PIX_W-1:0]    pixel;
    logic                is_cmd;

    assign req_in = '{code: req_code, fg: req_fg, bg: req_bg};

    pixel_sequencer u_seq (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_in         (req_in),
        .req_open_frame (req_open_frame),
        .out_valid      (out_valid),
        .out_ready      (out_ready),
        .is_cmd         (is_cmd),
        .row            (row),
        .col            (col),
        .cur            (cur),
        .done           (done)
    );

    glyph_rom #(
        .LO_CODE (FIRST_CODE),
        .HI_CODE (LAST_CODE)
    ) u_rom (
        .code     (cur.code),
        .row      (row),
        .lit_bits (lit_bits)
    );

    colour_expand u_expand (
        .lit_bits (lit_bits),
        .col      (col),
        .fg       (cur.fg),
        .bg       (cur.bg),
        .pixel    (pixel)
    );

    assign out_is_cmd = is_cmd;
    assign out_data   = is_cmd ? CMD_MEM_WRITE : pixel;

    AST_CMD_WORD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_cmd) |-> (out_data == 16'h002C)); // R5

    AST_PIXEL_COLOUR: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is_cmd) |-> (out_data == cur.fg || out_data == cur.bg)); // R3

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_is_cmd))); // R7

endmodule

// File: tb/tb_glyph_stream.sv
module tb_glyph_stream;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_code = 8'h00;
    logic [15:0] req_fg = 16'h0000;
    logic [15:0] req_bg = 16'h0000;
    logic        req_open_frame = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_data;
    logic        out_is_cmd;
    logic        done;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    glyph_stream dut (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_code       (req_code),
        .req_fg         (req_fg),
        .req_bg         (req_bg),
        .req_open_frame (req_open_frame),
        .out_valid      (out_valid),
        .out_ready      (out_ready),
        .out_data       (out_data),
        .out_is_cmd     (out_is_cmd),
        .done           (done)
    );

    localparam int NV = 8;
    localparam logic [7:0]  V_CODE  [NV] = '{8'h41, 8'h7E, 8'h20, 8'h21, 8'h1F, 8'h7F, 8'hFF, 8'h5A};
    localparam logic [15:0] V_FG    [NV] = '{16'hF800, 16'h07E0, 16'hFFFF, 16'h001F, 16'hABCD, 16'h1234, 16'hFFFF, 16'h8410};
    localparam logic [15:0] V_BG    [NV] = '{16'h001F, 16'h0000, 16'h0841, 16'hFFE0, 16'h5555, 16'hEDCB, 16'h0000, 16'h2104};
    localparam bit          V_CMD   [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam int          V_STALL [NV] = '{0, 3, 0, 2, 0, 0, 4, 5};

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Row word from R4/R6.
    function automatic logic [15:0] exp_row(input logic [7:0] c, input int r);
        logic [15:0] two;
        if (c < 8'h20 || c > 8'h7E) return 16'hFF00;
        if (c == 8'h20 || r < 2 || r > 13) return 16'h0000;
        two = {c, c} << (r % 8);
        return {two[15:8], 8'h00};
    endfunction

    function automatic logic [15:0] exp_word(input logic [7:0] c, input logic [15:0] fg,
                                             input logic [15:0] bg, input bit cmd, input int k);
        int p;
        logic [15:0] rw;
        if (cmd && k == 0) return 16'h002C;
        p  = cmd ? k - 1 : k;
        rw = exp_row(c, p / 8);
        return rw[15 - (p % 8)] ? fg : bg;
    endfunction

    task automatic launch(input logic [7:0] c, input logic [15:0] fg,
                          input logic [15:0] bg, input bit cmd);
        @(negedge clk);
        chk(req_ready == 1'b1, "R8", "idle req_ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_code = c; req_fg = fg; req_bg = bg; req_open_frame = cmd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Collects one cell starting at the current negedge. If inject_at matches
    // a word index, a second request (c2) is raised and held.
    task automatic collect(input logic [7:0] c, input logic [15:0] fg, input logic [15:0] bg,
                           input bit cmd, input int stall, input int inject_at,
                           input logic [7:0] c2, input bit cmd2);
        int n, k, cyc;
        bit ready, was_stalled;
        logic [15:0] held;
        logic [15:0] ew;
        string tag;
        n = cmd ? 129 : 128;
        k = 0; cyc = 0; was_stalled = 1'b0; held = '0;
        tag = (c < 8'h20 || c > 8'h7E) ? "R6 R3" : "R2 R3 R4";
        while (k < n && cyc < 3000) begin
            if (was_stalled)
                chk(out_valid && out_data == held, "R7", "word held during stall",
                    32'(out_data), 32'(held));
            if (k == inject_at) begin
                req_valid = 1'b1; req_code = c2; req_fg = 16'h7BEF; req_bg = 16'h0010;
                req_open_frame = cmd2;
            end
            if (k > inject_at)
                chk(req_ready == 1'b0, "R8", "req_ready low while busy", 32'(req_ready), 32'd0);
            ready = (stall == 0) ? 1'b1 : ((cyc % stall) != 0);
            out_ready = ready;
            if (out_valid && ready) begin
                ew = exp_word(c, fg, bg, cmd, k);
                if (cmd && k == 0) begin
                    chk(out_data == ew && out_is_cmd, "R5", "command word",
                        {15'd0, out_is_cmd, out_data}, {16'd1, ew});
                end else begin
                    chk(out_data == ew, tag, $sformatf("pixel %0d code %h", cmd ? k-1 : k, c),
                        32'(out_data), 32'(ew));
                    chk(out_is_cmd == 1'b0, "R9", "pixel kind", 32'(out_is_cmd), 32'd0);
                end
                k++;
            end
            was_stalled = out_valid && !ready;
            held = out_data;
            cyc++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(k == n, "R2", "words transferred per cell", 32'(k), 32'(n));
        chk(done == 1'b1, "R8", "done after last pixel", 32'(done), 32'd1);
        chk(req_ready == 1'b1, "R8", "req_ready with done", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(done == 1'b0, "R8", "done lasts one cycle", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && done == 1'b0 && req_ready == 1'b1, "R1", "during reset",
            {29'd0, out_valid, done, req_ready}, 32'd1);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0 && done == 1'b0 && req_ready == 1'b1, "R1", "after reset",
            {29'd0, out_valid, done, req_ready}, 32'd1);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            launch(V_CODE[i], V_FG[i], V_BG[i], V_CMD[i]);
            collect(V_CODE[i], V_FG[i], V_BG[i], V_CMD[i], V_STALL[i], 9999, 8'h00, 1'b0);
        end

        // R5: no command word when the flag is clear; first word is a pixel
        launch(8'h30, 16'hFFFF, 16'h0000, 1'b0);
        chk(out_valid && !out_is_cmd, "R5", "no command without flag",
            {30'd0, out_valid, out_is_cmd}, 32'd2);
        collect(8'h30, 16'hFFFF, 16'h0000, 1'b0, 0, 9999, 8'h00, 1'b0);

        // R8: request raised mid-cell is held off and then taken at done
        launch(8'h4D, 16'hF81F, 16'h0400, 1'b0);
        collect(8'h4D, 16'hF81F, 16'h0400, 1'b0, 3, 40, 8'h6B, 1'b1);
        collect(8'h6B, 16'h7BEF, 16'h0010, 1'b1, 0, 9999, 8'h00, 1'b0);

        // R1: reset in the middle of a cell
        launch(8'h55, 16'h1111, 16'h2222, 1'b1);
        out_ready = 1'b1;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        out_ready = 1'b0;
        chk(out_valid == 1'b0 && done == 1'b0 && req_ready == 1'b1, "R1", "after mid-cell reset",
            {29'd0, out_valid, done, req_ready}, 32'd1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog R2 R8 run did not complete actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule